// File: doc/BRIEF.md
# Banked OR Execute Unit

This unit carries out two logical-OR instructions of a small accumulator machine. It holds an 8-bit working register, negative and zero flags, a 4-bit bank register and a 4096-byte data store organised as 16 banks of 256 bytes. An instruction word is offered with a valid strobe. When the unit is idle it accepts the word and steps through four phases: decode, operand read, combine, write-back. One clock after the last phase it raises a one-cycle completion pulse.

One form ORs the working register with an 8-bit literal held in the word. The other form ORs it with a byte from the data store. A per-word bit chooses the bank for that byte: either the bank register, or a fixed mapping that sends the low half of the offset range to bank 0 and the high half to bank 15. A second bit picks the destination, which is either the working register or the addressed byte. A test port reads and writes the store directly, and a load port sets the bank register.

Top module: `orExecUnit`

## Requirements
- R1: The word 0x09kk (upper byte 0000_1001) sets the working register to its old value OR kk. For example, 0x9A with literal 0x35 gives 0xBF.
- R2: A word whose bits [15:10] are 000100 reads the byte at offset bits [7:0] and ORs it with the working register. With bit 9 (destination) at 0, the result goes to the working register and the byte is left unchanged. For example, 0x91 OR 0x13 gives 0x93.
- R3: With bit 9 at 1 the result is written to the addressed byte and the working register is left unchanged.
- R4: With bit 8 at 0 the bank register is ignored: offsets 0x00–0x7F address bank 0 and offsets 0x80–0xFF address bank 15. With bit 8 at 1 the byte address is bank*256 + offset, and test-port address bits [11:8] give the bank.
- R5: Both forms set the negative flag to bit 7 of the result and the zero flag to (result == 0). No other event changes the flags.
- R6: Once a word is accepted at a clock edge, busy is high for the next four cycles. Done is high for exactly one cycle, four edges after the accepting edge, and results are visible in that same cycle.
- R7: A valid strobe that arrives while busy is ignored.
- R8: Any other word completes its four phases without changing the working register, the flags or the store, and raises the illegal flag together with done.
- R9: The bank register is sampled in the decode phase. A load in the accepting cycle applies to that word; a load in any later cycle applies only to later words.
- R10: The test port reads combinationally and writes on the clock edge. If a test write and an instruction write-back hit the same byte on the same edge, the write-back wins.
- R11: A synchronous reset clears the working register, both flags, the bank register, busy and done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instrValid | input | 1 | Instruction word offered |
| instrWord | input | 16 | Instruction word |
| bankLoad | input | 1 | Load strobe for the bank register |
| bankIn | input | 4 | New bank register value |
| memWrEn | input | 1 | Test-port write enable |
| memAddr | input | 12 | Test-port byte address (bank, offset) |
| memWrData | input | 8 | Test-port write data |
| memRdData | output | 8 | Test-port read data |
| wreg | output | 8 | Working register |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | One-cycle completion pulse |
| illegalOp | output | 1 | Unsupported word completed (with done) |

## Verification
Two activities can share a single edge, and the bench provokes both cases. The first is an instruction in flight together with a change to its operand's addressing: a bank load is driven in the accepting cycle and another in the decode cycle, and the bench checks that the first load redirects the write-back and the second does not. The second is a test-port write landing on the same edge as a file write-back. The bench aims it at the same byte, where the write-back value must remain, and at a neighbouring byte, where the test data must remain.

// File: rtl/orExecPkg.sv
package orExecPkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DECODE,
    PH_READ,
    PH_PROC,
    PH_WRITE
  } phase_t;

  // strobes and decoded fields passed from control to datapath
  typedef struct packed {
    logic latchAddr;
    logic readOp;
    logic process;
    logic commit;
    logic useLit;
    logic toFile;
    logic useAccess;
  } orStrobe_t;

  localparam logic [7:0] LIT_OPCODE = 8'h09;
  localparam logic [5:0] REG_OPCODE = 6'b000100;

endpackage

// File: rtl/orExecCtrl.sv
module orExecCtrl
  import orExecPkg::*;
#(
  parameter int INSTR_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  output orStrobe_t          strb,
  output logic [7:0]         irLow,
  output logic               busy,
  output logic               done,
  output logic               illegalOp
);

  phase_t phase;
  logic [INSTR_W-1:0] instrQ;
  logic isLit, isReg, legal;

  assign isLit = (instrQ[15:8] == LIT_OPCODE);
  assign isReg = (instrQ[15:10] == REG_OPCODE);
  assign legal = isLit | isReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      instrQ    <= '0;
      done      <= 1'b0;
      illegalOp <= 1'b0;
    end else begin
      done      <= 1'b0;
      illegalOp <= 1'b0;
      unique case (phase)
        PH_IDLE: if (instrValid) begin
          instrQ <= instrWord;
          phase  <= PH_DECODE;
        end
        PH_DECODE: phase <= PH_READ;
        PH_READ:   phase <= PH_PROC;
        PH_PROC:   phase <= PH_WRITE;
        PH_WRITE: begin
          phase     <= PH_IDLE;
          done      <= 1'b1;
          illegalOp <= ~legal;
        end
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.latchAddr = (phase == PH_DECODE);
    strb.readOp    = (phase == PH_READ);
    strb.process   = (phase == PH_PROC);
    strb.commit    = (phase == PH_WRITE) && legal;
    strb.useLit    = isLit;
    strb.toFile    = isReg && instrQ[9];
    strb.useAccess = ~instrQ[8];
  end

  assign irLow = instrQ[7:0];
  assign busy  = (phase != PH_IDLE);

  AST_DONE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(phase) == PH_WRITE); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_DECODE_TO_READ: assert property (@(posedge clk) disable iff (rst)
    phase == PH_DECODE |=> phase == PH_READ); // R6
  AST_BUSY_HOLDS_WORD: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(instrQ)); // R7
  AST_ILLEGAL_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    illegalOp |-> done); // R8

endmodule

// File: rtl/orExecDatapath.sv
module orExecDatapath
  import orExecPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BANK_W = 4,
  parameter int OFF_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  orStrobe_t                strb,
  input  logic [OFF_W-1:0]         irLow,
  input  logic                     bankLoad,
  input  logic [BANK_W-1:0]        bankIn,
  input  logic                     memWrEn,
  input  logic [BANK_W+OFF_W-1:0]  memAddr,
  input  logic [DATA_W-1:0]        memWrData,
  output logic [DATA_W-1:0]        memRdData,
  output logic [DATA_W-1:0]        wreg,
  output logic                     flagN,
  output logic                     flagZ
);

  localparam int ADDR_W = BANK_W + OFF_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [BANK_W-1:0] LOW_BANK  = '0;
  localparam logic [BANK_W-1:0] HIGH_BANK = '1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [BANK_W-1:0] bankReg;
  logic [ADDR_W-1:0] effAddr;
  logic [DATA_W-1:0] operand, result;
  logic [BANK_W-1:0] bankSel;

  assign bankSel = strb.useAccess ? (irLow[OFF_W-1] ? HIGH_BANK : LOW_BANK) : bankReg;

  always_ff @(posedge clk) begin
    if (rst) bankReg <= '0;
    else if (bankLoad) bankReg <= bankIn;
  end

  always_ff @(posedge clk) begin
    if (strb.latchAddr) effAddr <= {bankSel, irLow};
    if (strb.readOp)    operand <= strb.useLit ? irLow[DATA_W-1:0] : mem[effAddr];
    if (strb.process)   result  <= wreg | operand;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wreg  <= '0;
      flagN <= 1'b0;
      flagZ <= 1'b0;
    end else if (strb.commit) begin
      if (!strb.toFile) wreg <= result;
      flagN <= result[DATA_W-1];
      flagZ <= (result == '0);
    end
  end

  // test write first, write-back last so it wins on a shared byte
  always_ff @(posedge clk) begin
    if (memWrEn) mem[memAddr] <= memWrData;
    if (strb.commit && strb.toFile) mem[effAddr] <= result;
  end

  assign memRdData = mem[memAddr];

  AST_WREG_ONLY_AT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !strb.commit |=> $stable(wreg)); // R8
  AST_FILE_KEEPS_WREG: assert property (@(posedge clk) disable iff (rst)
    (strb.commit && strb.toFile) |=> $stable(wreg)); // R3
  AST_FLAG_N_FROM_RESULT: assert property (@(posedge clk) disable iff (rst)
    strb.commit |=> flagN == $past(result[DATA_W-1])); // R5
  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
    !strb.commit |=> $stable(flagN) && $stable(flagZ)); // R5

endmodule

// File: rtl/orExecUnit.sv
module orExecUnit
  import orExecPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BANK_W  = 4,
  parameter int INSTR_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 instrValid,
  input  logic [INSTR_W-1:0]   instrWord,
  input  logic                 bankLoad,
  input  logic [BANK_W-1:0]    bankIn,
  input  logic                 memWrEn,
  input  logic [BANK_W+7:0]    memAddr,
  input  logic [DATA_W-1:0]    memWrData,
  output logic [DATA_W-1:0]    memRdData,
  output logic [DATA_W-1:0]    wreg,
  output logic                 flagN,
  output logic                 flagZ,
  output logic                 busy,
  output logic                 done,
  output logic                 illegalOp
);

  localparam int OFF_W = 8;

  orStrobe_t strb;
  logic [OFF_W-1:0] irLow;

  orExecCtrl #(.INSTR_W(INSTR_W)) i_ctrl (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instrWord(instrWord),
    .strb(strb), .irLow(irLow), .busy(busy), .done(done), .illegalOp(illegalOp)
  );

  orExecDatapath #(.DATA_W(DATA_W), .BANK_W(BANK_W), .OFF_W(OFF_W)) i_dp (
    .clk(clk), .rst(rst), .strb(strb), .irLow(irLow),
    .bankLoad(bankLoad), .bankIn(bankIn),
    .memWrEn(memWrEn), .memAddr(memAddr), .memWrData(memWrData),
    .memRdData(memRdData), .wreg(wreg), .flagN(flagN), .flagZ(flagZ)
  );

endmodule

// File: tb/test_orExecUnit.sv
module test_orExecUnit;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instrValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic bankLoad = 1'b0;
  logic [3:0] bankIn = '0;
  logic memWrEn = 1'b0;
  logic [11:0] memAddr = '0;
  logic [7:0] memWrData = '0;
  logic [7:0] memRdData, wreg;
  logic flagN, flagZ, busy, done, illegalOp;

  always #10 clk = ~clk;

  orExecUnit i_orExecUnit (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instrWord(instrWord),
    .bankLoad(bankLoad), .bankIn(bankIn), .memWrEn(memWrEn), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData), .wreg(wreg), .flagN(flagN),
    .flagZ(flagZ), .busy(busy), .done(done), .illegalOp(illegalOp)
  );

  typedef struct packed {
    logic [7:0] w;
    logic n;
    logic z;
    logic ill;
  } expItem_t;

  expItem_t expQ[$];
  string tagQ[$];

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 1'b0;

  logic [7:0] mW;
  logic mN, mZ;
  logic [3:0] mBank;
  logic [7:0] mMem [4096];

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compare every completion against the scoreboard queue
  always @(negedge clk) begin
    if (!rst && done) begin
      if (expQ.size() == 0) begin
        chk("R6 unexpected done", 16'd1, 16'd0);
      end else begin
        expItem_t e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk({t, " wreg"}, {8'h0, wreg}, {8'h0, e.w});
        chk({t, " N/Z"}, {14'h0, flagN, flagZ}, {14'h0, e.n, e.z});
        chk({t, " illegal (R8)"}, {15'h0, illegalOp}, {15'h0, e.ill});
      end
    end
  end

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mW = '0; mN = 1'b0; mZ = 1'b0; mBank = '0;
    chk("R11 wreg", {8'h0, wreg}, 16'h0);
    chk("R11 flags", {14'h0, flagN, flagZ}, 16'h0);
    chk("R11 busy/done", {14'h0, busy, done}, 16'h0);
  endtask

  task automatic poke(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    memWrEn = 1'b1; memAddr = a; memWrData = d;
    @(negedge clk);
    memWrEn = 1'b0;
    mMem[a] = d;
  endtask

  task automatic peek(input logic [11:0] a, input string tag);
    @(negedge clk);
    memAddr = a;
    #1;
    chk(tag, {8'h0, memRdData}, {8'h0, mMem[a]});
  endtask

  // driver: computes the expected outcome, pushes it, then drives the phases
  task automatic issue(input logic [15:0] w, input string tag,
                       input bit ldNow = 0, input logic [3:0] bNow = 0,
                       input bit ldLate = 0, input logic [3:0] bLate = 0,
                       input bit hold = 0,
                       input bit tw = 0, input logic [11:0] twA = 0,
                       input logic [7:0] twD = 0);
    logic isLit, isReg;
    logic [11:0] eff;
    logic [7:0] opnd, res;
    if (ldNow) mBank = bNow;
    isLit = (w[15:8] == 8'h09);
    isReg = (w[15:10] == 6'b000100);
    eff = !w[8] ? {(w[7] ? 4'hF : 4'h0), w[7:0]} : {mBank, w[7:0]};
    opnd = isLit ? w[7:0] : mMem[eff];
    res = mW | opnd;
    if (tw) mMem[twA] = twD;
    if (isLit || isReg) begin
      if (isReg && w[9]) mMem[eff] = res;
      else mW = res;
      mN = res[7];
      mZ = (res == 8'h00);
    end
    expQ.push_back('{w: mW, n: mN, z: mZ, ill: !(isLit || isReg)});
    tagQ.push_back(tag);
    if (ldLate) mBank = bLate;

    @(negedge clk);
    instrValid = 1'b1; instrWord = w; bankLoad = ldNow; bankIn = bNow;
    @(negedge clk);
    chk("R6 busy after accept", {14'h0, busy, done}, 16'h2);
    instrValid = hold; instrWord = 16'h09FF;
    bankLoad = ldLate; bankIn = bLate;
    @(negedge clk);
    bankLoad = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R6 no early done", {15'h0, done}, 16'h0);
    instrValid = 1'b0;
    memWrEn = tw; memAddr = twA; memWrData = twD;
    @(negedge clk);
    memWrEn = 1'b0;
    chk("R6 done after four phases", {15'h0, done}, 16'h1);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mMem[i] = 8'h00;
    for (int i = 0; i < 4096; i++) begin
      @(negedge clk);
      memWrEn = 1'b1; memAddr = i[11:0]; memWrData = 8'h00;
    end
    @(negedge clk);
    memWrEn = 1'b0;
    doReset();

    issue(16'h099A, "R5 negative flag");
    issue(16'h0935, "R1 literal 9A|35");
    chk("R1 result BF", {8'h0, wreg}, 16'h00BF);

    doReset();
    issue(16'h0900, "R5 zero flag");
    issue(16'h0991, "R1 literal load");
    poke(12'h020, 8'h13);
    issue(16'h1120, "R2 file to wreg");
    chk("R2 result 93", {8'h0, wreg}, 16'h0093);
    peek(12'h020, "R2 file byte unchanged");

    poke(12'h3A5, 8'h0C);
    issue(16'h13A5, "R3 write to file", 1, 4'd3);
    peek(12'h3A5, "R3 file byte written");

    poke(12'h005, 8'h20);
    poke(12'hF90, 8'h01);
    issue(16'h1205, "R4 access low half");
    issue(16'h1290, "R4 access high half");
    peek(12'h005, "R4 bank 0 written");
    peek(12'hF90, "R4 bank 15 written");
    peek(12'h305, "R4 bank register ignored low");
    peek(12'h390, "R4 bank register ignored high");

    issue(16'h0A55, "R8 illegal near literal");
    issue(16'hFFFF, "R8 illegal all ones");
    issue(16'h1B05, "R8 illegal near file form");
    peek(12'h305, "R8 store untouched");
    peek(12'h005, "R8 store untouched access");

    issue(16'h1310, "R9 load in accept cycle", 1, 4'd5, 1, 4'd7);
    peek(12'h510, "R9 early load used");
    peek(12'h710, "R9 late load not used");
    issue(16'h1310, "R9 late load for next word");
    peek(12'h710, "R9 late load applies later");

    issue(16'h0904, "R7 valid while busy", 0, 0, 0, 0, 1);
    @(negedge clk);
    chk("R7 no extra accept", {15'h0, busy}, 16'h0);

    issue(16'h1310, "R10 same-byte collision", 0, 0, 0, 0, 0, 1, 12'h710, 8'h5A);
    peek(12'h710, "R10 write-back wins");
    issue(16'h1310, "R10 neighbour write", 0, 0, 0, 0, 0, 1, 12'h711, 8'h66);
    peek(12'h711, "R10 test write kept");

    doReset();
    issue(16'h1120, "R11 bank register cleared");

    repeat (2) @(negedge clk);
    if (expQ.size() != 0) chk("R6 missing done", 16'd0, 16'd1);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    repeat (30000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

endmodule